// File: doc/BRIEF.md
# PWM Capture DMA Request Generator

This block raises the two DMA request lines that belong to one PWM submodule. The read request tells a DMA engine to drain the capture FIFOs. The write request tells it to refill the compare value registers. A 16-bit control word, written over a plain register bus, decides which events raise each request.

The read request has four sources, selected by a 2-bit field: off, FIFO watermark, local sync and reload. In watermark mode a per-FIFO enable mask picks which of the six watermark flags count. A combine bit then merges the chosen flags with either OR or AND. In sync mode and reload mode the request is latched on the event.

Each request line works as a valid/ready pair with its acknowledge strobe. The request is valid, and a one-cycle acknowledge is the ready that retires it. A latched request holds until acknowledged, so back-pressure from a slow DMA engine loses nothing. Events that arrive while a request is pending merge into that request. In watermark mode the request is a registered level and the acknowledge has no effect.

Top module: `pwm_cap_dma_req`

## Requirements
- R1: After reset the control word, `rd_req` and `wr_req` are all 0. Control bits 15..10 always read 0 and ignore written values.
- R2: A cycle with `reg_we` high loads bits 9..0 of `reg_wdata`. `reg_rdata` shows the new value, and the new value governs request generation, from the following cycle onward.
- R3: When control bit 9 is 1, `reload_flag` high at a clock edge sets `wr_req` at that edge. `wr_req` then holds until an edge with `wr_ack` high and no new reload. While bit 9 is 0, `wr_req` is 0 at the next edge.
- R4: Mode field bits 7..6 = 00 produces no read request. Any pending read request is cleared at the first edge at which 00 governs.
- R5: Mode 01 with bit 8 = 0: at each edge `rd_req` becomes the OR of (`wm_flags[i]` AND enable bit i). Enable bits 5..0 map to `wm_flags[5..0]` in the order A1, A0, B1, B0, X1, X0.
- R6: Mode 01 with bit 8 = 1: at each edge `rd_req` becomes the AND over all i of (`wm_flags[i]` OR NOT enable bit i), provided at least one enable is set. `rd_ack` has no effect in mode 01.
- R7: Mode 01 with all six enable bits at 0 leaves `rd_req` at 0 at the next edge.
- R8: Mode 10: `sync_pulse` high at an edge sets `rd_req`. `rd_req` then holds until an edge with `rd_ack` high and no new sync pulse.
- R9: Mode 11: `reload_flag` high at an edge sets `rd_req`, with the same acknowledge rule as R8.
- R10: Bit 8 has no effect on `rd_req` in modes 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control word write enable |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word readback |
| wm_flags | input | 6 | Watermark flags: [5]=A1, [4]=A0, [3]=B1, [2]=B0, [1]=X1, [0]=X0 |
| sync_pulse | input | 1 | Local sync event (VAL1 compare match) |
| reload_flag | input | 1 | Reload flag |
| rd_ack | input | 1 | DMA acknowledge for the read request |
| wr_ack | input | 1 | DMA acknowledge for the write request |
| rd_req | output | 1 | Capture FIFO read request |
| wr_req | output | 1 | Value register write request |

## Verification
The assertions assume that every input is stable around the rising clock edge. They place no limit on when the acknowledge strobes arrive. An acknowledge may come with no request pending, or in the same cycle as a new event; the set-over-clear rule covers both cases. The stimulus changes inputs only on the falling edge. It issues acknowledges, events and control writes at random, in any combination, and biases the watermark flags toward 1 so that the AND combine fires as well as the OR.

// File: rtl/pwm_dma_pkg.sv
package pwm_dma_pkg;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned NUM_WM   = 6;
  localparam int unsigned LIVE_W   = NUM_WM + 4;
  localparam int unsigned RSVD_W   = CTRL_W - LIVE_W;

  typedef enum logic [1:0] {
    SRC_OFF    = 2'b00,
    SRC_WMARK  = 2'b01,
    SRC_SYNC   = 2'b10,
    SRC_RELOAD = 2'b11
  } rd_src_e;

  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    logic              wr_en;
    logic              wm_and;
    rd_src_e           src;
    logic [NUM_WM-1:0] wm_en;
  } ctrl_t;
endpackage

// File: rtl/pdr_ctrl_reg.sv
module pdr_ctrl_reg #(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned LIVE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  localparam logic [REG_W-1:0] LIVE_MASK = {{(REG_W-LIVE_W){1'b0}}, {LIVE_W{1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & LIVE_MASK;
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == ($past(wdata) & LIVE_MASK));

  // R2
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/pdr_wm_combine.sv
module pdr_wm_combine #(
  parameter int unsigned NUM_WM = 6
) (
  input  logic [NUM_WM-1:0] flags,
  input  logic [NUM_WM-1:0] en,
  input  logic              use_and,
  output logic              hit
);
  logic [NUM_WM-1:0] or_term;
  logic [NUM_WM-1:0] and_term;

  for (genvar g = 0; g < NUM_WM; g++) begin : g_term
    assign or_term[g]  = en[g] & flags[g];
    assign and_term[g] = ~en[g] | flags[g];
  end

  assign hit = (|en) & (use_and ? (&and_term) : (|or_term));

  // R7
  none_chk: assert final ((|en) || !hit);
endmodule

// File: rtl/pdr_req_latch.sv
module pdr_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (load) q <= load_val;
    else           q <= set | (q & ~clr);
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && q && !clr) |=> q);

  // R9
  set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && set) |=> q);
endmodule

// File: rtl/pwm_cap_dma_req.sv
module pwm_cap_dma_req
  import pwm_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic [NUM_WM-1:0] wm_flags,
  input  logic              sync_pulse,
  input  logic              reload_flag,
  input  logic              rd_ack,
  input  logic              wr_ack,
  output logic              rd_req,
  output logic              wr_req
);
  logic [CTRL_W-1:0] ctrl_bits;
  ctrl_t             ctrl;
  logic              wm_hit;
  logic              rd_load;
  logic              rd_load_val;
  logic              rd_set;

  pdr_ctrl_reg #(.REG_W(CTRL_W), .LIVE_W(LIVE_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .q(ctrl_bits)
  );

  assign ctrl      = ctrl_t'(ctrl_bits);
  assign reg_rdata = ctrl_bits;

  pdr_wm_combine #(.NUM_WM(NUM_WM)) i_wm (
    .flags(wm_flags), .en(ctrl.wm_en), .use_and(ctrl.wm_and), .hit(wm_hit)
  );

  always_comb begin
    rd_load     = 1'b0;
    rd_load_val = 1'b0;
    rd_set      = 1'b0;
    unique case (ctrl.src)
      SRC_OFF:    rd_load = 1'b1;
      SRC_WMARK: begin
        rd_load     = 1'b1;
        rd_load_val = wm_hit;
      end
      SRC_SYNC:   rd_set = sync_pulse;
      SRC_RELOAD: rd_set = reload_flag;
      default:    rd_load = 1'b1;
    endcase
  end

  pdr_req_latch i_rd (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .load_val(rd_load_val),
    .set(rd_set), .clr(rd_ack), .q(rd_req)
  );

  pdr_req_latch i_wr (
    .clk(clk), .rst_n(rst_n), .load(~ctrl.wr_en), .load_val(1'b0),
    .set(reload_flag), .clr(wr_ack), .q(wr_req)
  );

  // R1
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.rsvd == '0);

  // R4
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.src == SRC_OFF) |=> !rd_req);

  // R7
  no_wm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.src == SRC_WMARK && ctrl.wm_en == '0) |=> !rd_req);

  // R3
  wr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.wr_en |=> !wr_req);

  // R3
  wr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.wr_en && reload_flag) |=> wr_req);
endmodule

// File: tb/test_pwm_cap_dma_req.sv
module test_pwm_cap_dma_req;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [5:0]  wm_flags = '0;
  logic        sync_pulse = 1'b0;
  logic        reload_flag = 1'b0;
  logic        rd_ack = 1'b0;
  logic        wr_ack = 1'b0;
  logic        rd_req;
  logic        wr_req;

  int total = 0;
  int bad = 0;

  logic [15:0] m_ctrl = '0;
  logic        m_rd = 1'b0;
  logic        m_wr = 1'b0;

  always #10 clk = ~clk;

  pwm_cap_dma_req i_pwm_cap_dma_req (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wm_flags(wm_flags), .sync_pulse(sync_pulse),
    .reload_flag(reload_flag), .rd_ack(rd_ack), .wr_ack(wr_ack),
    .rd_req(rd_req), .wr_req(wr_req)
  );

  function automatic logic f_hit(logic [15:0] c, logic [5:0] f);
    logic [5:0] en;
    en = c[5:0];
    if (en == 6'd0) return 1'b0;
    if (c[8]) return &(f | ~en);
    return |(f & en);
  endfunction

  function automatic logic f_rd_next(logic [15:0] c, logic cur, logic [5:0] f,
                                     logic sy, logic rl, logic ack);
    case (c[7:6])
      2'b00:   return 1'b0;
      2'b01:   return f_hit(c, f);
      2'b10:   return sy | (cur & ~ack);
      default: return rl | (cur & ~ack);
    endcase
  endfunction

  function automatic string f_tag(logic [15:0] c);
    case (c[7:6])
      2'b00:   return "R4";
      2'b01:   return (c[5:0] == 6'd0) ? "R7" : (c[8] ? "R6" : "R5");
      2'b10:   return c[8] ? "R10" : "R8";
      default: return c[8] ? "R10" : "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic we, logic [15:0] wd, logic [5:0] f, logic sy,
                      logic rl, logic ra, logic wa);
    logic [15:0] n_ctrl;
    logic        n_rd;
    logic        n_wr;
    string       tag;
    reg_we = we; reg_wdata = wd; wm_flags = f;
    sync_pulse = sy; reload_flag = rl; rd_ack = ra; wr_ack = wa;
    n_ctrl = we ? (wd & 16'h03FF) : m_ctrl;
    n_rd   = f_rd_next(m_ctrl, m_rd, f, sy, rl, ra);
    n_wr   = m_ctrl[9] ? (rl | (m_wr & ~wa)) : 1'b0;
    tag    = f_tag(m_ctrl);
    @(posedge clk);
    @(negedge clk);
    m_ctrl = n_ctrl; m_rd = n_rd; m_wr = n_wr;
    check(tag, {15'd0, rd_req}, {15'd0, m_rd});
    check("R3", {15'd0, wr_req}, {15'd0, m_wr});
    check(we ? "R2" : "R1", reg_rdata, m_ctrl);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", reg_rdata, 16'h0000);
    check("R1", {15'd0, rd_req}, 16'h0);
    check("R1", {15'd0, wr_req}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reserved bits
    step(1'b1, 16'hFFFF, 6'h00, 0, 0, 0, 0);
    check("R1", reg_rdata, 16'h03FF);
    // R6 AND with disabled FIFOs treated as true
    step(1'b1, 16'h0143, 6'h00, 0, 0, 0, 0);
    step(1'b0, 16'h0000, 6'h03, 0, 0, 1, 0);
    check("R6", {15'd0, rd_req}, 16'h1);
    step(1'b0, 16'h0000, 6'h01, 0, 0, 0, 0);
    check("R6", {15'd0, rd_req}, 16'h0);
    // R5 OR
    step(1'b1, 16'h0050, 6'h00, 0, 0, 0, 0);
    step(1'b0, 16'h0000, 6'h10, 0, 0, 0, 0);
    check("R5", {15'd0, rd_req}, 16'h1);
    // R7 no enables
    step(1'b1, 16'h0140, 6'h3F, 0, 0, 0, 0);
    step(1'b0, 16'h0000, 6'h3F, 0, 0, 0, 0);
    check("R7", {15'd0, rd_req}, 16'h0);
    // R8 sync latch then R4 clear by mode 00
    step(1'b1, 16'h0080, 6'h00, 0, 0, 0, 0);
    step(1'b0, 16'h0000, 6'h00, 1, 0, 0, 0);
    step(1'b0, 16'h0000, 6'h00, 0, 0, 0, 0);
    check("R8", {15'd0, rd_req}, 16'h1);
    step(1'b1, 16'h0000, 6'h00, 0, 0, 0, 0);
    check("R8", {15'd0, rd_req}, 16'h1);
    step(1'b0, 16'h0000, 6'h00, 0, 0, 0, 0);
    check("R4", {15'd0, rd_req}, 16'h0);
    // R9 and R3: reload sets both, acks clear
    step(1'b1, 16'h02C0, 6'h00, 0, 0, 0, 0);
    step(1'b0, 16'h0000, 6'h00, 0, 1, 0, 0);
    step(1'b0, 16'h0000, 6'h00, 0, 0, 1, 1);
    check("R9", {15'd0, rd_req}, 16'h0);
    check("R3", {15'd0, wr_req}, 16'h0);
    // R10 combine bit ignored in reload mode
    step(1'b1, 16'h03C0, 6'h00, 0, 0, 0, 0);
    step(1'b0, 16'h0000, 6'h00, 0, 1, 0, 0);
    check("R10", {15'd0, rd_req}, 16'h1);
    for (int i = 0; i < 4000; i++) begin
      logic        we;
      logic [5:0]  f;
      we = ($urandom % 16) == 0;
      f  = 6'($urandom) | 6'($urandom);
      step(we, 16'($urandom), f, ($urandom % 6) == 0, ($urandom % 6) == 0,
           ($urandom % 4) == 0, ($urandom % 4) == 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule